// File: doc/BRIEF.md
# Atomic Locked Access Controller

This block sits between a core's memory pipeline and a shared system bus and carries out one locked read-modify-write at a time. For each accepted request it first decides how atomicity will be protected. An access that is cacheable and stays inside one 64-byte line is protected locally: other agents are asked to write back and invalidate their copies of the line. Any other access takes the global bus lock, and the external lock line stays high until the write has finished.

After that decision the block reads the operand, computes the new value (add, exchange or compare-exchange), writes the result back to the same address and reports the original memory value with a one-cycle done pulse. Requests from other bus masters for the bus are granted freely, except while the bus lock is held. During that time they wait, and they are granted in the cycle after the lock is released. Cache arrays, the coherence protocol and bus timing stay outside the block; each is reached through a simple request/acknowledge pair.

Top module: `lk_atomic_ctrl`

## Requirements
- R1: A request with `req_cacheable`=1 that does not cross a line takes the cache-lock path. `bus_lock` stays 0 for the whole operation and one snoop/invalidate handshake is made.
- R2: A request with `req_cacheable`=0, or one that crosses a line, holds `bus_lock` high from the lock-acquire step through the write handshake. `bus_lock` is 0 in the cycle that `done` is high.
- R3: Once `bus_lock` has been high for more than one cycle, `ext_bus_grant` is 0 for as long as `bus_lock` stays high.
- R4: If `ext_bus_req` is high while a bus lock is held, `ext_bus_grant` is 1 in the cycle after the `done` cycle. Outside a bus lock, `ext_bus_grant` follows `ext_bus_req` one cycle later.
- R5: On the cache-lock path the snoop handshake completes before the read is requested.
- R6: The read happens before the write, and both use the request address unchanged on `mem_addr`.
- R7: Line crossing is decided by the start offset within the 64-byte line (`addr[5:0]`) plus the access size in bytes. The access crosses when that sum is greater than 64. `req_size` encodes 0=1, 1=2, 2=4 and 3=8 bytes.
- R8: `req_op`=00 (add) writes (old + operand) masked to the access width. Data is right-aligned and the bits above the width are written as 0.
- R9: `req_op`=01 (exchange) writes the operand masked to the access width. `req_op`=11 writes the original value back unchanged.
- R10: `req_op`=10 (compare-exchange) writes the operand masked to the access width when the masked old value equals the masked `req_compare`. Otherwise it writes the original value back unchanged.
- R11: `done` is high for exactly one cycle per operation, in the cycle after the write acknowledge, and `done_data` then carries the original value that was read.
- R12: After reset `bus_lock`, `done`, `ext_bus_grant`, `snoop_req`, `mem_rd_req` and `mem_wr_req` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Locked request present (taken when req_ready is 1) |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_cacheable | input | 1 | Access is cacheable |
| req_op | input | 2 | 00 add, 01 exchange, 10 compare-exchange, 11 write-back unchanged |
| req_operand | input | DATA_W | Source operand |
| req_compare | input | DATA_W | Compare value for compare-exchange |
| ext_bus_req | input | 1 | Another master asks for the bus |
| ext_bus_grant | output | 1 | Bus handed to the other master |
| bus_lock | output | 1 | Global bus lock |
| snoop_req | output | 1 | Write back and invalidate request for the line at mem_addr |
| snoop_ack | input | 1 | Snoop/invalidate finished |
| mem_addr | output | ADDR_W | Address for snoop, read and write |
| mem_rd_req | output | 1 | Read request |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Read data, right-aligned |
| mem_wr_req | output | 1 | Write request |
| mem_wr_data | output | DATA_W | Write data, right-aligned |
| mem_wr_ack | input | 1 | Write finished |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DATA_W | Original memory value |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 64-bit data and a 64-byte line. The 6-bit line offset therefore lets an 8-byte access sit exactly on the last legal start (offset 56) and one byte past it (offset 57), so both sides of the crossing rule are tested. The full 64-bit data path also lets a 1-byte add overflow inside a wider stored value, which shows the width masking. Holding `ext_bus_req` high across bus-locked and cache-locked operations exercises the grant blocking, the release-timed grant and the free grant.

// File: rtl/lk_pkg.sv
// Shared types of the locked access controller.
// Assumes: one operation in flight at a time.
package lk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_SNOOP,
        ST_BUSLOCK,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_RELEASE
    } lk_state_e;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_XCHG = 2'b01,
        OP_CMPX = 2'b10,
        OP_KEEP = 2'b11
    } lk_op_e;
endpackage

// File: rtl/lk_span_check.sv
// Decides whether an access runs past the end of its cache line.
// Assumes: LINE_BYTES is a power of two, at least 8; size code s means 2**s bytes.
module lk_span_check #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              crosses
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    logic [OFF_W:0] end_pos;

    // End position of the access within the line, one past the last byte.
    always_comb begin
        end_pos = {1'b0, addr[OFF_W-1:0]} + ((OFF_W+1)'(1) << size);
        crosses = end_pos > (OFF_W+1)'(LINE_BYTES);
    end
endmodule

// File: rtl/lk_rmw_alu.sv
// Computes the value to write back for a locked read-modify-write.
// Assumes: right-aligned data; the result is masked to the access width,
// except where the original value is kept.
module lk_rmw_alu
    import lk_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  lk_op_e            op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] compare,
    output logic [DATA_W-1:0] new_val
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] mask;

    // Byte mask covering the access width.
    always_comb begin
        mask = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (b < (32'd1 << size)) mask[b*8 +: 8] = 8'hFF;
        end
    end

    // Result selection by operation.
    always_comb begin
        unique case (op)
            OP_ADD:  new_val = (old_val + operand) & mask;
            OP_XCHG: new_val = operand & mask;
            OP_CMPX: new_val = ((old_val & mask) == (compare & mask)) ? (operand & mask) : old_val;
            default: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/lk_grant_ctrl.sv
// Hands the bus to another master, holding its request back while a lock is held.
// Assumes: the requester keeps ext_req high until it has been served.
module lk_grant_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req,
    input  logic lock_hold,
    output logic grant
);
    // Registered grant; a held-back request is served once the lock drops.
    always_ff @(posedge clk) begin
        if (!rst_n) grant <= 1'b0;
        else        grant <= ext_req && !lock_hold;
    end
endmodule

// File: rtl/lk_atomic_ctrl.sv
// Locked read-modify-write sequencer.
// Takes one request, picks a cache lock or a bus lock, then runs
// snoop/lock, read, modify, write and release.
// Assumes: handshake partners raise their ack while the matching request is high.
module lk_atomic_ctrl
    import lk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_cacheable,
    input  logic [1:0]        req_op,
    input  logic [DATA_W-1:0] req_operand,
    input  logic [DATA_W-1:0] req_compare,
    input  logic              ext_bus_req,
    output logic              ext_bus_grant,
    output logic              bus_lock,
    output logic              snoop_req,
    input  logic              snoop_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_req,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack,
    output logic              done,
    output logic [DATA_W-1:0] done_data
);
    lk_state_e         state;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic              cache_q;
    lk_op_e            op_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] cmp_q;
    logic              use_bus_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] new_q;
    logic              crosses;
    logic [DATA_W-1:0] alu_out;

    lk_span_check #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_span (
        .addr    (addr_q),
        .size    (size_q),
        .crosses (crosses)
    );

    lk_rmw_alu #(.DATA_W(DATA_W)) u_alu (
        .op      (op_q),
        .size    (size_q),
        .old_val (old_q),
        .operand (opnd_q),
        .compare (cmp_q),
        .new_val (alu_out)
    );

    lk_grant_ctrl u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_req   (ext_bus_req),
        .lock_hold (bus_lock),
        .grant     (ext_bus_grant)
    );

    // Handshake and lock outputs decoded from the current step.
    always_comb begin
        req_ready   = (state == ST_IDLE);
        snoop_req   = (state == ST_SNOOP);
        mem_rd_req  = (state == ST_READ);
        mem_wr_req  = (state == ST_WRITE);
        mem_addr    = addr_q;
        mem_wr_data = new_q;
        bus_lock    = use_bus_q && (state == ST_BUSLOCK || state == ST_READ ||
                                    state == ST_MODIFY  || state == ST_WRITE);
    end

    // Sequencer: one locked operation from capture to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            size_q    <= '0;
            cache_q   <= 1'b0;
            op_q      <= OP_ADD;
            opnd_q    <= '0;
            cmp_q     <= '0;
            use_bus_q <= 1'b0;
            old_q     <= '0;
            new_q     <= '0;
            done      <= 1'b0;
            done_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    addr_q  <= req_addr;
                    size_q  <= req_size;
                    cache_q <= req_cacheable;
                    op_q    <= lk_op_e'(req_op);
                    opnd_q  <= req_operand;
                    cmp_q   <= req_compare;
                    state   <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    use_bus_q <= !cache_q || crosses;
                    state     <= (!cache_q || crosses) ? ST_BUSLOCK : ST_SNOOP;
                end
                ST_SNOOP:   if (snoop_ack) state <= ST_READ;
                ST_BUSLOCK: if (!ext_bus_grant) state <= ST_READ;
                ST_READ: if (mem_rd_ack) begin
                    old_q <= mem_rd_data;
                    state <= ST_MODIFY;
                end
                ST_MODIFY: begin
                    new_q <= alu_out;
                    state <= ST_WRITE;
                end
                ST_WRITE: if (mem_wr_ack) begin
                    done      <= 1'b1;
                    done_data <= old_q;
                    state     <= ST_RELEASE;
                end
                default: begin
                    use_bus_q <= 1'b0;
                    state     <= ST_IDLE;
                end
            endcase
        end
    end

    // R1
    snoop_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_req |-> !bus_lock);

    // R2
    lock_drop_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) |-> done);

    // R3
    no_grant_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lock && $past(bus_lock)) |-> !ext_bus_grant);

    // R5
    snoop_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rd_req) && !bus_lock) |-> $past(snoop_req));

    // R6
    write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_req) |-> $past(!mem_rd_req) && !snoop_req);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/lk_atomic_ctrl_test.sv
module lk_atomic_ctrl_test;
    localparam int AW = 32;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          req_cacheable = 1'b0;
    logic [1:0]    req_op = '0;
    logic [DW-1:0] req_operand = '0;
    logic [DW-1:0] req_compare = '0;
    logic          ext_bus_req = 1'b0;
    logic          ext_bus_grant;
    logic          bus_lock;
    logic          snoop_req;
    logic          snoop_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd_req;
    logic          mem_rd_ack = 1'b0;
    logic [DW-1:0] mem_rd_data = '0;
    logic          mem_wr_req;
    logic [DW-1:0] mem_wr_data;
    logic          mem_wr_ack = 1'b0;
    logic          done;
    logic [DW-1:0] done_data;

    lk_atomic_ctrl uut (.*);

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] old_v;
        logic [DW-1:0] new_v;
        logic          bus;
    } exp_t;
    exp_t sb[$];

    // bench-side observation state
    logic [DW-1:0] mem_val = '0;
    logic [DW-1:0] wr_data_seen;
    logic [AW-1:0] wr_addr_seen;
    logic [AW-1:0] rd_addr_seen;
    logic          saw_lock, saw_snoop, lock_at_wr, prev_lock;
    int            cyc = 0, t_snoop, t_rd, t_wr, viol, done_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model(input logic [1:0] op, input logic [1:0] sz,
                                            input logic [DW-1:0] o, input logic [DW-1:0] a,
                                            input logic [DW-1:0] c);
        logic [DW-1:0] m;
        case (sz)
            2'd0: m = 64'hFF;
            2'd1: m = 64'hFFFF;
            2'd2: m = 64'hFFFF_FFFF;
            default: m = '1;
        endcase
        case (op)
            2'b00: return (o + a) & m;
            2'b01: return a & m;
            2'b10: return ((o & m) == (c & m)) ? (a & m) : o;
            default: return o;
        endcase
    endfunction

    // Memory, snoop and ack responder plus phase recorder.
    always @(negedge clk) begin
        cyc++;
        snoop_ack   <= snoop_req;
        mem_rd_ack  <= mem_rd_req;
        mem_rd_data <= mem_val;
        mem_wr_ack  <= mem_wr_req;
        if (bus_lock) saw_lock = 1'b1;
        if (snoop_req) begin saw_snoop = 1'b1; t_snoop = cyc; end
        if (mem_rd_req && t_rd < 0) begin t_rd = cyc; rd_addr_seen = mem_addr; end
        if (mem_wr_req && t_wr < 0) begin
            t_wr = cyc; wr_data_seen = mem_wr_data; wr_addr_seen = mem_addr; lock_at_wr = bus_lock;
        end
        if (bus_lock && prev_lock && ext_bus_grant) viol++;
        prev_lock = bus_lock;
    end

    // Monitor: pops expected item on done and compares.
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            if (sb.size() == 0) begin
                chk(0, "R11 unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                chk(done_data === e.old_v, "R11 done_data", done_data, e.old_v);
                chk(wr_data_seen === e.new_v, "R8/R9/R10 write data", wr_data_seen, e.new_v);
                chk(wr_addr_seen === e.addr && rd_addr_seen === e.addr, "R6 address", wr_addr_seen, e.addr);
                chk(t_rd > 0 && t_wr > t_rd, "R6 read before write", t_wr, t_rd);
                chk(!bus_lock, "R2 lock low at done", bus_lock, 0);
                if (e.bus) begin
                    chk(saw_lock && lock_at_wr && !saw_snoop, "R2 bus lock path", {saw_lock, lock_at_wr, saw_snoop}, 3'b110);
                    chk(viol == 0, "R3 grant during lock", viol, 0);
                end else begin
                    chk(!saw_lock && saw_snoop, "R1 cache lock path", {saw_lock, saw_snoop}, 2'b01);
                    chk(t_snoop < t_rd, "R5 snoop before read", t_snoop, t_rd);
                end
            end
            done_cnt++;
        end
    end

    // Driver: pushes the expected item and issues one request.
    task automatic run_op(input logic [AW-1:0] a, input logic [1:0] sz, input logic cache,
                          input logic [1:0] op, input logic [DW-1:0] opnd, input logic [DW-1:0] cmp,
                          input logic [DW-1:0] mv, input logic exp_bus, input logic other_req);
        exp_t e;
        int target;
        e.addr = a; e.old_v = mv; e.new_v = model(op, sz, mv, opnd, cmp); e.bus = exp_bus;
        sb.push_back(e);
        target = done_cnt + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        mem_val = mv;
        ext_bus_req = other_req;
        saw_lock = 0; saw_snoop = 0; lock_at_wr = 0;
        t_snoop = -1; t_rd = -1; t_wr = -1; viol = 0;
        req_addr = a; req_size = sz; req_cacheable = cache; req_op = op;
        req_operand = opnd; req_compare = cmp; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait (done_cnt == target);
        @(negedge clk);
        chk(!done, "R11 done one cycle", done, 0);
        if (other_req) chk(ext_bus_grant, "R4 grant after release", ext_bus_grant, 1);
        ext_bus_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!bus_lock && !done && !ext_bus_grant && !snoop_req && !mem_rd_req && !mem_wr_req && req_ready,
            "R12 reset state", {bus_lock, done, ext_bus_grant, req_ready}, 4'b0001);

        // R1 R8 cacheable, inside line, 8-byte add
        run_op(32'h100, 2'd3, 1, 2'b00, 64'h5, 0, 64'h10, 0, 0);
        // R2 R3 R4 R9 non-cacheable exchange with other master waiting
        run_op(32'h200, 2'd2, 0, 2'b01, 64'hAABB_CCDD_1122_3344, 0, 64'h7777, 1, 1);
        // R7 R10 crossing at offset 63 size 2, compare match
        run_op(32'h13F, 2'd1, 1, 2'b10, 64'h00BE, 64'h1234, 64'h1234, 1, 1);
        // R7 offset 56 size 8 stays in line
        run_op(32'h238, 2'd3, 1, 2'b00, 64'h1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
        // R7 offset 57 size 8 crosses
        run_op(32'h239, 2'd3, 1, 2'b00, 64'h2, 0, 64'h40, 1, 0);
        // R10 compare mismatch keeps original
        run_op(32'h300, 2'd2, 1, 2'b10, 64'h99, 64'h5, 64'hDEAD_0006, 0, 0);
        // R8 one-byte add overflow, upper bytes cleared
        run_op(32'h401, 2'd0, 1, 2'b00, 64'h1, 0, 64'h12FF, 0, 0);
        // R9 opcode 11 writes original back
        run_op(32'h508, 2'd2, 0, 2'b11, 64'h55, 0, 64'h0123_4567_89AB_CDEF, 1, 0);
        // R1 R4 cache lock does not hold back another master
        ext_bus_req = 1'b1;
        repeat (2) @(negedge clk);
        chk(ext_bus_grant, "R4 free grant", ext_bus_grant, 1);
        run_op(32'h600, 2'd2, 1, 2'b01, 64'h3, 0, 64'h9, 0, 1);
        chk(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule